// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt events for a small 8-bit processor core and routes them into two request lines: one for high priority and one for low priority. It has five event sources. Three are external pins, each with its own trigger edge. One is a rollover detector on a free-running timer value, which can count in 8-bit or 16-bit mode. The last is a change detector on four port pins. Each source owns a sticky flag, an enable bit and, except for external pin 0, a priority bit.

Software uses a small register port to control the block. Through it, software sets enables, trigger edges, priorities and the timer width. It also clears flags by writing ones to them. Reading the port-pin register returns the synchronized pin levels and reloads the reference value that the change detector compares against.

While the core is in a low-power state, any flagged external pin whose enable is set drives a wake-up output. This happens whatever the global enables are. The global enables only decide whether a request is presented afterwards.

Top module: `irq_ctl`

## Requirements
- R1: When an external pin's edge bit (cfg register, address 1, bits 2:0, bit n for pin n) is 1, a low-to-high transition on that pin sets its flag (flag register, address 2, bit n), and a high-to-low transition does not.
- R2: When that edge bit is 0, a high-to-low transition sets the flag, and a low-to-high transition does not.
- R3: A set flag stays set until software writes 1 to its bit in the flag register. Writing 0 leaves it unchanged.
- R4: When a source's enable bit is 0 (control register, address 0: bit 2+n for pin n, bit 5 for timer, bit 6 for port change), that source raises neither request, but its flag still sets and reads back as 1.
- R5: External pin 0 always requests at high priority. Pins 1 and 2 request high when their priority bit (cfg bit 3 for pin 1, bit 4 for pin 2) is 1, and low when it is 0.
- R6: With the timer mode bit (cfg bit 7) at 0, a step of the low byte of the timer value from FFh to 00h sets the timer flag (flag bit 3). That source routes by cfg bit 5: 1 selects high, 0 selects low.
- R7: With the timer mode bit at 1, only a step from FFFFh to 0000h sets the timer flag. An 8-bit rollover inside the count does not.
- R8: Any difference between the four port pins and the reference value sets the change flag (flag bit 4). A read of address 3 reloads the reference with the current pin levels. The change source routes by cfg bit 6.
- R9: The high request is present only while the high global enable (control bit 0) is 1. The low request is present only while the low global enable (control bit 1) is 1.
- R10: While `sleep` is 1, `wake` is 1 exactly when some external pin has both its flag and its enable set, independent of both global enables.
- R11: When a flag-clear write and a new event for the same flag fall in the same cycle, the flag ends up set.
- R12: After reset all registers and flags read 0, and `irq_hi`, `irq_lo` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (matters for address 3) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| ext_pin | input | 3 | External interrupt pins (asynchronous) |
| port_pin | input | 4 | Port pins watched for change (asynchronous) |
| tmr_val | input | 16 | Current timer count |
| sleep | input | 1 | Core is in a low-power state |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |
| wake | output | 1 | Wake-up request |

## Verification
The edge logic is exercised with random pins, random edge settings and random start levels. Each trial is one transition, so a polarity mix-up shows as a flag on the wrong direction. Priority routing is checked one flag at a time while priority bits are flipped, which exposes a source fixed to the wrong line or a pin-0 priority that can be changed. Timer sequences are chosen to separate 8-bit from 16-bit rollovers, and the port is driven both before and after a snapshot read. A timer rollover placed on the same cycle as a clear write shows which of the two wins.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NUM_EXT = 3;
    localparam int CHG_W   = 4;
    localparam int TMR_W   = 16;
    localparam int NUM_SRC = NUM_EXT + 2;
    localparam int TMR_BIT = NUM_EXT;
    localparam int CHG_BIT = NUM_EXT + 1;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;
    localparam logic [ADDR_W-1:0] A_PORT = 2'd3;

    typedef struct packed {
        logic               spare;
        logic               chg_en;
        logic               tmr_en;
        logic [NUM_EXT-1:0] ext_en;
        logic               glob_lo;
        logic               glob_hi;
    } ctrl_t;

    typedef struct packed {
        logic               tmr16;
        logic               chg_hi;
        logic               tmr_hi;
        logic [NUM_EXT-2:0] ext_hi;
        logic [NUM_EXT-1:0] rise;
    } cfg_t;

    function automatic logic [NUM_SRC-1:0] hi_route(input cfg_t c);
        return {c.chg_hi, c.tmr_hi, c.ext_hi, 1'b1};
    endfunction

    function automatic logic [NUM_SRC-1:0] src_enables(input ctrl_t c);
        return {c.chg_en, c.tmr_en, c.ext_en};
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] rise,
    output logic [N-1:0] hit
);
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        always_comb begin
            if (rise[i]) hit[i] = lvl[i] & ~prev[i];
            else         hit[i] = ~lvl[i] & prev[i];
        end
    end
endmodule

// File: rtl/irq_chg_det.sv
module irq_chg_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic         snap_load,
    output logic         hit
);
    logic [W-1:0] snap;

    always_ff @(posedge clk) begin
        if (rst)            snap <= '0;
        else if (snap_load) snap <= lvl;
    end

    assign hit = |(lvl ^ snap);
endmodule

// File: rtl/irq_tmr_ovf.sv
module irq_tmr_ovf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] val,
    input  logic         wide,
    output logic         hit
);
    localparam int HALF = W / 2;
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= val;
    end

    always_comb begin
        if (wide) hit = (&prev) && (val == '0);
        else      hit = (&prev[HALF-1:0]) && (val[HALF-1:0] == '0);
    end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [irq_pkg::ADDR_W-1:0] addr,
    input  logic [irq_pkg::DATA_W-1:0] wdata,
    output logic [irq_pkg::DATA_W-1:0] rdata,
    input  logic [irq_pkg::NUM_EXT-1:0] ext_pin,
    input  logic [irq_pkg::CHG_W-1:0]  port_pin,
    input  logic [irq_pkg::TMR_W-1:0]  tmr_val,
    input  logic                      sleep,
    output logic                      irq_hi,
    output logic                      irq_lo,
    output logic                      wake
);
    ctrl_t              ctrl_q;
    cfg_t               cfg_q;
    logic [NUM_SRC-1:0] flags_q;
    logic [NUM_EXT-1:0] ext_s;
    logic [CHG_W-1:0]   port_s;
    logic [NUM_EXT-1:0] ext_hit;
    logic               chg_hit;
    logic               tmr_hit;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] to_hi;

    irq_sync #(.W(NUM_EXT)) i_sync_ext (
        .clk(clk), .rst(rst), .d(ext_pin), .q(ext_s)
    );
    irq_sync #(.W(CHG_W)) i_sync_port (
        .clk(clk), .rst(rst), .d(port_pin), .q(port_s)
    );
    irq_edge_det #(.N(NUM_EXT)) i_edge (
        .clk(clk), .rst(rst), .lvl(ext_s), .rise(cfg_q.rise), .hit(ext_hit)
    );
    irq_chg_det #(.W(CHG_W)) i_chg (
        .clk(clk), .rst(rst), .lvl(port_s),
        .snap_load(rd_en && addr == A_PORT), .hit(chg_hit)
    );
    irq_tmr_ovf #(.W(TMR_W)) i_tmr (
        .clk(clk), .rst(rst), .val(tmr_val), .wide(cfg_q.tmr16), .hit(tmr_hit)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[NUM_EXT-1:0] = ext_hit;
        set_vec[TMR_BIT] = tmr_hit;
        set_vec[CHG_BIT] = chg_hit;
        clr_vec = (wr_en && addr == A_FLAG) ? wdata[NUM_SRC-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            cfg_q   <= '0;
            flags_q <= '0;
        end else begin
            if (wr_en && addr == A_CTRL) ctrl_q <= ctrl_t'(wdata);
            if (wr_en && addr == A_CFG)  cfg_q  <= cfg_t'(wdata);
            flags_q <= (flags_q & ~clr_vec) | set_vec;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_CFG:   rdata = cfg_q;
            A_FLAG:  rdata = DATA_W'(flags_q);
            default: rdata = DATA_W'(port_s);
        endcase
    end

    assign live   = flags_q & src_enables(ctrl_q);
    assign to_hi  = hi_route(cfg_q);
    assign irq_hi = ctrl_q.glob_hi & |(live & to_hi);
    assign irq_lo = ctrl_q.glob_lo & |(live & ~to_hi);
    assign wake   = sleep & |(flags_q[NUM_EXT-1:0] & ctrl_q.ext_en);
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk
    import irq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wdata,
    input logic                sleep,
    input logic                irq_hi,
    input logic                irq_lo,
    input logic                wake,
    input ctrl_t               ctrl_q,
    input logic [NUM_SRC-1:0]  flags_q
);
    AST_HI_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        irq_hi |-> ctrl_q.glob_hi);                                         // R9
    AST_LO_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> ctrl_q.glob_lo);                                         // R9
    AST_PIN0_NEVER_LOW: assert property (@(posedge clk) disable iff (rst)
        (flags_q == NUM_SRC'(1)) |-> !irq_lo);                              // R5
    AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        wake |-> sleep);                                                    // R10
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (flags_q[0] && !(wr_en && addr == A_FLAG && wdata[0])) |=> flags_q[0]); // R3
    AST_NO_FLAG_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (flags_q == '0) |-> (!irq_hi && !irq_lo && !wake));                 // R4
endmodule

bind irq_ctl irq_ctl_chk i_irq_ctl_chk (.*);

// File: tb/test_irq_ctl.sv
module test_irq_ctl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [2:0]  ext_pin = '0;
    logic [3:0]  port_pin = '0;
    logic [15:0] tmr_val = '0;
    logic        sleep = 1'b0;
    logic        irq_hi, irq_lo, wake;
    int          n_checks = 0, n_errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctl i_irq_ctl (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic edge_fires(input logic rise_sel, input logic from_lvl);
        return rise_sel ? (from_lvl == 1'b0) : (from_lvl == 1'b1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h5a17));
        tick(3); rst = 1'b0; tick(1);

        // R12 reset state
        rd(2'd0, r); chk("R12 ctrl", r, 8'h00);
        rd(2'd1, r); chk("R12 cfg", r, 8'h00);
        rd(2'd2, r); chk("R12 flags", r, 8'h00);
        chk("R12 outputs", {irq_hi, irq_lo, wake}, 3'b000);

        // R1 / R2 random single transitions, sources disabled (R4 flag still sets)
        for (int k = 0; k < 24; k++) begin
            int   pin = $urandom_range(2, 0);
            logic start = 1'($urandom);
            logic [2:0] rise = 3'($urandom);
            wr(2'd1, {5'b0, rise});
            ext_pin[pin] = start; tick(5);
            wr(2'd2, 8'hFF);
            ext_pin[pin] = ~start; tick(5);
            rd(2'd2, r);
            chk(rise[pin] ? "R1 rising edge" : "R2 falling edge", r,
                8'(edge_fires(rise[pin], start)) << pin);
        end

        // bring all pins low, rising edges, clear
        ext_pin = 3'b000; wr(2'd1, 8'h07); tick(5); wr(2'd2, 8'hFF);

        // R5 routing: pin0 high only
        wr(2'd0, 8'b0001_1111);               // both globals, all ext enabled
        ext_pin[0] = 1'b1; tick(5);
        chk("R5 pin0 high", {irq_hi, irq_lo}, 2'b10);
        wr(2'd2, 8'h01); tick(1);
        ext_pin[1] = 1'b1; tick(5);            // cfg ext1 priority 0 -> low
        chk("R5 pin1 low", {irq_hi, irq_lo}, 2'b01);
        wr(2'd1, 8'h0F); tick(1);               // pin1 priority high
        chk("R5 pin1 high", {irq_hi, irq_lo}, 2'b10);

        // R4 masking
        wr(2'd0, 8'b0001_0111);                // pin1 disabled
        chk("R4 masked no request", {irq_hi, irq_lo}, 2'b00);
        rd(2'd2, r); chk("R4 masked flag visible", r, 8'h02);

        // R3 persistence
        tick(20); rd(2'd2, r); chk("R3 flag persists", r, 8'h02);
        wr(2'd2, 8'h00); rd(2'd2, r); chk("R3 zero write keeps", r, 8'h02);
        wr(2'd2, 8'h02); rd(2'd2, r); chk("R3 clear", r, 8'h00);

        // R9 / R10: pin0 flagged and enabled, globals off, asleep
        wr(2'd0, 8'b0000_0100);
        ext_pin[0] = 1'b0; tick(3); ext_pin[0] = 1'b1; tick(5);
        chk("R9 global hi off", {irq_hi, irq_lo}, 2'b00);
        sleep = 1'b1; tick(1);
        chk("R10 wake without global", wake, 1'b1);
        wr(2'd0, 8'b0000_0101);
        chk("R9 global hi on", irq_hi, 1'b1);
        wr(2'd0, 8'b0000_0001);
        chk("R10 no wake when disabled", wake, 1'b0);
        sleep = 1'b0; wr(2'd2, 8'hFF);

        // R6 8-bit rollover, low routing
        wr(2'd0, 8'b0010_0010);                // timer enabled, glob_lo
        wr(2'd1, 8'h07);
        tmr_val = 16'h00FE; tick(1); tmr_val = 16'h00FF; tick(1);
        tmr_val = 16'h0100; tick(2);
        rd(2'd2, r); chk("R6 8-bit rollover", r, 8'h08);
        chk("R6 timer low route", irq_lo, 1'b1);
        wr(2'd2, 8'hFF);

        // R7 16-bit mode
        wr(2'd1, 8'h87);
        tmr_val = 16'h01FF; tick(1); tmr_val = 16'h0200; tick(2);
        rd(2'd2, r); chk("R7 no flag on byte rollover", r, 8'h00);
        tmr_val = 16'hFFFF; tick(1); tmr_val = 16'h0000; tick(2);
        rd(2'd2, r); chk("R7 full rollover", r, 8'h08);
        wr(2'd2, 8'hFF);

        // R11 set beats clear on the same cycle
        wr(2'd1, 8'h07);
        tmr_val = 16'h00FF; tick(1);
        tmr_val = 16'h0100; wr_en = 1'b1; addr = 2'd2; wdata = 8'h08;
        tick(1); wr_en = 1'b0;
        rd(2'd2, r); chk("R11 set wins", r, 8'h08);
        wr(2'd2, 8'hFF);

        // R8 port change against snapshot
        wr(2'd1, 8'h47); wr(2'd0, 8'b0100_0001);
        port_pin = 4'b0100; tick(5);
        rd(2'd2, r); chk("R8 change flag", r, 8'h10);
        chk("R8 change high route", irq_hi, 1'b1);
        wr(2'd2, 8'h10); tick(1);
        rd(2'd2, r); chk("R8 mismatch resets flag", r, 8'h10);
        rd(2'd3, r); chk("R8 port read", r, 8'h04);
        wr(2'd2, 8'h10); tick(2);
        rd(2'd2, r); chk("R8 snapshot quiets", r, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule